// File: doc/BRIEF.md
# Packed-Index Register Gather Unit

The unit executes a vector indexed move. One issued instruction names a destination register `rd`, a source register `rs1`, a 4-bit function code and a vector length. The source register does not hold data. It holds a list of register numbers packed side by side, each 8, 16, 32 or XLEN bits wide, with the width chosen by the function code. For every element the unit takes the next register number from that packed list, reads the register it names and writes the value to `rd` plus the element number. One load instruction can therefore supply several gather indices at once.

The unit owns a small register file with one read port and one write port. The sequencer uses both ports while an instruction is running. While the unit is idle, a host port reaches the same two ports, so surrounding logic can load operands and read results. Every source value is read into an internal holding store before the first write is made. The result is then the same as an atomic gather, even when the destinations overlap the sources or the index register.

Top module: `pidx_gather`

## Requirements
- R1: After reset, `busy`, `done` and `fault` are low, and every register reads 0 through the host read port.
- R2: An issue is accepted only when the unit is idle, `issue_op` is 7'b1010111, `issue_f3` is 3'b000 and `issue_fn[1:0]` is 2'b10. Any other issue, including the floating-point code `issue_fn[1:0]` = 2'b11, is ignored: no busy, no done, no register change, and `fault` is unchanged.
- R3: `issue_fn[3:2]` selects the index width W: 0 selects XLEN bits, 1 selects 8 bits, 2 selects 16 bits and 3 selects 32 bits.
- R4: Index i is bits [i*W +: W] of the value held in `rs1`, starting at the least significant bits. For example, with W=8 and a source value of 0x00020301, four elements use the indices 1, 3, 2, 0 in that order.
- R5: The number of elements processed is the smaller of `issue_vl` and XLEN/W.
- R6: For each processed element i with an in-range index, register (rd+i) mod NREGS receives the value that the indexed register held before the instruction. This holds even when a destination is also a source or the index register.
- R7: An index at or above NREGS skips its element, and that destination keeps its value. The skip sets `fault`, which stays set until the next accepted instruction clears it.
- R8: For n processed elements with n > 0, `busy` is high from the cycle after acceptance. `done` is a one-cycle pulse with `busy` low, appearing 2n+1 clock edges after the accepting edge.
- R9: An accepted instruction with `issue_vl` = 0 raises `done` on the clock edge after acceptance. It writes no register and never raises `busy`.
- R10: While idle, a host write takes effect at the clock edge, and `host_rdata` shows the register at `host_raddr` combinationally. Host writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue strobe, sampled at the clock edge |
| issue_op | input | 7 | Major opcode field |
| issue_f3 | input | 3 | Minor function field |
| issue_fn | input | 4 | Function code: [3:2] index width, [1:0] operation kind |
| issue_rd | input | AW | First destination register |
| issue_rs1 | input | AW | Register holding the packed indices |
| issue_vl | input | VLW | Requested vector length |
| host_we | input | 1 | Host write enable, used only while idle |
| host_waddr | input | AW | Host write address |
| host_wdata | input | XLEN | Host write data |
| host_raddr | input | AW | Host read address |
| host_rdata | output | XLEN | Host read data, valid while idle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | An index of the last accepted instruction was out of range |

## Verification
The assertions assume that the start of a run is always caused by an issue strobe in the previous cycle. They also assume that the unit's own write strobe is never raised outside a run. The stimulus issues only while the unit is idle, and it drives `issue_valid` for exactly one cycle per instruction. Random index values are drawn from a range slightly above the register count, so that skipped elements and the `fault` flag are exercised along with valid gathers. Host writes during a run are made only at chosen points, to confirm that they are ignored.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam logic [6:0] PG_OPCODE = 7'b1010111;
    localparam logic [2:0] PG_MINOR  = 3'b000;
    localparam logic [1:0] PG_KIND_INT = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_GATHER  = 2'd2,
        ST_SCATTER = 2'd3
    } pg_state_e;

    // Lanes of a given width that fit in one register.
    function automatic int pg_capacity(input logic [1:0] wsel, input int xlen);
        case (wsel)
            2'd1:    return xlen / 8;
            2'd2:    return xlen / 16;
            2'd3:    return xlen / 32;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/pg_decode.sv
module pg_decode (
    input  logic [6:0] op,
    input  logic [2:0] f3,
    input  logic [3:0] fn,
    output logic       legal,
    output logic [1:0] wsel
);
    always_comb begin
        legal = (op == pg_pkg::PG_OPCODE) && (f3 == pg_pkg::PG_MINOR) &&
                (fn[1:0] == pg_pkg::PG_KIND_INT);
        wsel  = fn[3:2];
    end
endmodule

// File: rtl/pg_rf.sv
module pg_rf #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata
);
    logic [NREGS-1:0][XLEN-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pg_lane_pick.sv
module pg_lane_pick #(
    parameter int XLEN = 32,
    localparam int MAXE = XLEN / 8,
    localparam int EW   = $clog2(MAXE),
    localparam int N16  = XLEN / 16,
    localparam int N32  = XLEN / 32
) (
    input  logic [XLEN-1:0] src,
    input  logic [1:0]      wsel,
    input  logic [EW-1:0]   elem,
    output logic [XLEN-1:0] idx
);
    logic [MAXE-1:0][XLEN-1:0] ext8, ext16, ext32;

    for (genvar k = 0; k < MAXE; k++) begin : g_lane
        assign ext8[k] = XLEN'(src[k*8 +: 8]);
        if (k < N16) begin : g_w16
            assign ext16[k] = XLEN'(src[k*16 +: 16]);
        end else begin : g_w16_none
            assign ext16[k] = '0;
        end
        if (k < N32) begin : g_w32
            assign ext32[k] = XLEN'(src[k*32 +: 32]);
        end else begin : g_w32_none
            assign ext32[k] = '0;
        end
    end

    always_comb begin
        case (wsel)
            2'd1:    idx = ext8[elem];
            2'd2:    idx = ext16[elem];
            2'd3:    idx = ext32[elem];
            default: idx = (elem == '0) ? src : '0;
        endcase
    end
endmodule

// File: rtl/pg_seq.sv
module pg_seq #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int VLW   = 8,
    localparam int AW   = $clog2(NREGS),
    localparam int MAXE = XLEN / 8,
    localparam int EW   = $clog2(MAXE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            legal,
    input  logic [1:0]      wsel,
    input  logic [AW-1:0]   rd,
    input  logic [AW-1:0]   rs1,
    input  logic [VLW-1:0]  vl,
    output logic [AW-1:0]   rf_raddr,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            rf_we,
    output logic [AW-1:0]   rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            busy,
    output logic            done,
    output logic            fault
);
    import pg_pkg::*;

    typedef struct packed {
        pg_state_e                 st;
        logic [EW-1:0]             elem;
        logic [EW-1:0]             last;
        logic [AW-1:0]             rd;
        logic [AW-1:0]             rs1;
        logic [1:0]                wsel;
        logic [XLEN-1:0]           src;
        logic [MAXE-1:0][XLEN-1:0] hold;
        logic [MAXE-1:0]           skip;
        logic                      fault;
        logic                      done;
    } seq_t;

    seq_t st_d, st_q;
    logic [XLEN-1:0] cur_idx;

    pg_lane_pick #(.XLEN(XLEN)) pick_i (
        .src  (st_q.src),
        .wsel (st_q.wsel),
        .elem (st_q.elem),
        .idx  (cur_idx)
    );

    always_comb begin
        int cap;
        int eff;
        st_d      = st_q;
        st_d.done = 1'b0;
        rf_raddr  = st_q.rs1;
        rf_we     = 1'b0;
        rf_waddr  = st_q.rd + AW'(st_q.elem);
        rf_wdata  = st_q.hold[st_q.elem];
        cap       = pg_capacity(wsel, XLEN);
        eff       = (int'(vl) < cap) ? int'(vl) : cap;
        case (st_q.st)
            ST_IDLE: begin
                if (issue_valid && legal) begin
                    st_d.rd    = rd;
                    st_d.rs1   = rs1;
                    st_d.wsel  = wsel;
                    st_d.fault = 1'b0;
                    st_d.skip  = '0;
                    st_d.elem  = '0;
                    if (eff == 0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.last = EW'(eff - 1);
                        st_d.st   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                st_d.src = rf_rdata;
                st_d.st  = ST_GATHER;
            end
            ST_GATHER: begin
                rf_raddr = cur_idx[AW-1:0];
                if (cur_idx < XLEN'(NREGS)) begin
                    st_d.hold[st_q.elem] = rf_rdata;
                end else begin
                    st_d.skip[st_q.elem] = 1'b1;
                    st_d.fault           = 1'b1;
                end
                if (st_q.elem == st_q.last) begin
                    st_d.elem = '0;
                    st_d.st   = ST_SCATTER;
                end else begin
                    st_d.elem = st_q.elem + 1'b1;
                end
            end
            default: begin
                rf_we = !st_q.skip[st_q.elem];
                if (st_q.elem == st_q.last) begin
                    st_d.st   = ST_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.elem = st_q.elem + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = (st_q.st != ST_IDLE);
    assign done  = st_q.done;
    assign fault = st_q.fault;
endmodule

// File: rtl/pidx_gather.sv
module pidx_gather #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int VLW   = 8,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [6:0]      issue_op,
    input  logic [2:0]      issue_f3,
    input  logic [3:0]      issue_fn,
    input  logic [AW-1:0]   issue_rd,
    input  logic [AW-1:0]   issue_rs1,
    input  logic [VLW-1:0]  issue_vl,
    input  logic            host_we,
    input  logic [AW-1:0]   host_waddr,
    input  logic [XLEN-1:0] host_wdata,
    input  logic [AW-1:0]   host_raddr,
    output logic [XLEN-1:0] host_rdata,
    output logic            busy,
    output logic            done,
    output logic            fault
);
    logic            dec_legal;
    logic [1:0]      dec_wsel;
    logic [AW-1:0]   seq_raddr, seq_waddr, rf_raddr, rf_waddr;
    logic [XLEN-1:0] seq_wdata, rf_rdata, rf_wdata;
    logic            seq_we, rf_we;

    pg_decode dec_i (
        .op    (issue_op),
        .f3    (issue_f3),
        .fn    (issue_fn),
        .legal (dec_legal),
        .wsel  (dec_wsel)
    );

    pg_seq #(.XLEN(XLEN), .NREGS(NREGS), .VLW(VLW)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .legal       (dec_legal),
        .wsel        (dec_wsel),
        .rd          (issue_rd),
        .rs1         (issue_rs1),
        .vl          (issue_vl),
        .rf_raddr    (seq_raddr),
        .rf_rdata    (rf_rdata),
        .rf_we       (seq_we),
        .rf_waddr    (seq_waddr),
        .rf_wdata    (seq_wdata),
        .busy        (busy),
        .done        (done),
        .fault       (fault)
    );

    // Port ownership: sequencer while running, host while idle.
    always_comb begin
        rf_raddr = busy ? seq_raddr : host_raddr;
        rf_we    = busy ? seq_we    : host_we;
        rf_waddr = busy ? seq_waddr : host_waddr;
        rf_wdata = busy ? seq_wdata : host_wdata;
    end

    pg_rf #(.XLEN(XLEN), .NREGS(NREGS)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

    assign host_rdata = rf_rdata;
endmodule

// File: rtl/pidx_gather_chk.sv
module pidx_gather_chk (
    input logic clk,
    input logic rst_n,
    input logic issue_valid,
    input logic busy,
    input logic done,
    input logic fault,
    input logic seq_we
);
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_BUSY_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(issue_valid)); // R2
    AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |-> busy); // R6
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !issue_valid) |=> $stable(fault)); // R7
endmodule

bind pidx_gather pidx_gather_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .seq_we      (seq_we)
);

// File: tb/pidx_gather_tb_top.sv
module pidx_gather_tb_top;
    localparam int XLEN = 32;
    localparam int NREGS = 32;
    localparam int VLW = 8;
    localparam int AW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid = 1'b0;
    logic [6:0]      issue_op = '0;
    logic [2:0]      issue_f3 = '0;
    logic [3:0]      issue_fn = '0;
    logic [AW-1:0]   issue_rd = '0;
    logic [AW-1:0]   issue_rs1 = '0;
    logic [VLW-1:0]  issue_vl = '0;
    logic            host_we = 1'b0;
    logic [AW-1:0]   host_waddr = '0;
    logic [XLEN-1:0] host_wdata = '0;
    logic [AW-1:0]   host_raddr = '0;
    logic [XLEN-1:0] host_rdata;
    logic            busy, done, fault;

    int checks = 0;
    int fails = 0;
    logic [31:0] model [NREGS];
    logic        exp_fault = 1'b0;

    always #4 clk = ~clk;

    pidx_gather #(.XLEN(XLEN), .NREGS(NREGS), .VLW(VLW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_op(issue_op), .issue_f3(issue_f3), .issue_fn(issue_fn),
        .issue_rd(issue_rd), .issue_rs1(issue_rs1), .issue_vl(issue_vl),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .busy(busy), .done(done), .fault(fault)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_rf(input string tag);
        int bad = -1;
        logic [31:0] badv = '0;
        for (int r = 0; r < NREGS; r++) begin
            host_raddr = AW'(r);
            #1;
            if (bad < 0 && host_rdata !== model[r]) begin
                bad = r;
                badv = host_rdata;
            end
        end
        if (bad < 0) check(1'b1, tag, "regfile", 0, 0);
        else check(1'b0, tag, $sformatf("reg %0d", bad), badv, model[bad]);
    endtask

    task automatic hwrite(input int a, input logic [31:0] d);
        host_we = 1'b1; host_waddr = AW'(a); host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_we = 1'b0;
        model[a] = d;
    endtask

    function automatic int width_of(input logic [1:0] w);
        case (w)
            2'd1: return 8;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

    // Runs one issue and checks timing, fault and register file.
    task automatic run(input logic [6:0] op, input logic [2:0] f3, input logic [3:0] fn,
                       input int rd, input int rs1, input int vl, input string tag,
                       input int poke = -1);
        bit acc;
        int w, cap, n, cyc;
        logic [31:0] snap [NREGS];
        logic [63:0] idx;
        bit saw_busy;
        acc = (op == 7'b1010111) && (f3 == 3'b000) && (fn[1:0] == 2'b10);
        w = width_of(fn[3:2]);
        cap = 32 / w;
        n = (vl < cap) ? vl : cap;
        if (acc) begin
            for (int r = 0; r < NREGS; r++) snap[r] = model[r];
            exp_fault = 1'b0;
            for (int i = 0; i < n; i++) begin
                idx = (64'(snap[rs1]) >> (i * w)) & ((64'd1 << w) - 1);
                if (idx < NREGS) model[(rd + i) % NREGS] = snap[idx];
                else exp_fault = 1'b1;
            end
        end
        issue_valid = 1'b1; issue_op = op; issue_f3 = f3; issue_fn = fn;
        issue_rd = AW'(rd); issue_rs1 = AW'(rs1); issue_vl = VLW'(vl);
        @(posedge clk); @(negedge clk);
        issue_valid = 1'b0;
        cyc = 1;
        saw_busy = busy;
        if (acc && n > 0) check(busy == 1'b1, tag, "busy after accept", busy, 1);
        while (!done && cyc < 40) begin
            if (poke >= 0 && cyc == 2) begin
                host_we = 1'b1; host_waddr = AW'(poke); host_wdata = 32'hDEAD_BEEF;
            end
            @(posedge clk); @(negedge clk);
            host_we = 1'b0;
            cyc++;
            saw_busy = saw_busy | busy;
        end
        if (acc) begin
            check(cyc == ((n == 0) ? 1 : 2 * n + 2), tag, "done timing", cyc,
                  (n == 0) ? 1 : 2 * n + 2);
            check(busy == 1'b0, tag, "busy low at done", busy, 0);
            if (n == 0) check(saw_busy == 1'b0, tag, "busy for empty run", saw_busy, 0);
        end else begin
            check(!done && !saw_busy, tag, "ignored issue", {saw_busy, done}, 0);
        end
        check(fault == exp_fault, tag, "fault", fault, exp_fault);
        check_rf(tag);
    endtask

    localparam logic [6:0] OP = 7'b1010111;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREGS; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fault, "R1", "flags after reset", {busy, done, fault}, 0);
        check_rf("R1");

        // R10 host write and read while idle
        for (int r = 0; r < NREGS; r++) hwrite(r, 32'h1000_0000 + r * 32'h0101);
        check_rf("R10");

        // R4 packed example with overlap (R6): indices 1,3,2,0 into x3..x6
        hwrite(8, 32'h0002_0301);
        run(OP, 3'b000, 4'b0110, 3, 8, 4, "R4");
        // R9 empty vector
        run(OP, 3'b000, 4'b0110, 20, 8, 0, "R9");
        // R2 rejected: floating-point kind, swizzle kind, bad opcode, bad funct3
        run(OP, 3'b000, 4'b0111, 10, 8, 4, "R2");
        run(OP, 3'b000, 4'b0100, 10, 8, 4, "R2");
        run(7'b0110011, 3'b000, 4'b0110, 10, 8, 4, "R2");
        run(OP, 3'b001, 4'b0110, 10, 8, 4, "R2");
        // R3/R5 XLEN-wide index, vl clamped to one element
        hwrite(9, 32'd17);
        run(OP, 3'b000, 4'b0010, 12, 9, 3, "R5");
        // R3 16-bit lanes
        hwrite(9, 32'h0005_0018);
        run(OP, 3'b000, 4'b1010, 14, 9, 5, "R3");
        // R3 32-bit lanes
        run(OP, 3'b000, 4'b1110, 16, 9, 2, "R3");
        // R7 out-of-range middle index, fault then cleared
        hwrite(9, 32'h0428_0207);
        run(OP, 3'b000, 4'b0110, 20, 9, 4, "R7");
        run(OP, 3'b000, 4'b0110, 20, 9, 2, "R7");
        // R6 destination wrap and overwrite of index register
        hwrite(31, 32'h0103_1F1E);
        run(OP, 3'b000, 4'b0110, 30, 31, 4, "R6");
        // R10 host write during run is ignored
        run(OP, 3'b000, 4'b0110, 3, 8, 4, "R10", 25);

        // R8 random mix
        for (int t = 0; t < 300; t++) begin
            int rd, rs1, vl;
            logic [3:0] fn;
            if (($urandom % 3) == 0) hwrite($urandom % NREGS, $urandom);
            rs1 = $urandom % NREGS;
            hwrite(rs1, {8'($urandom % 36), 8'($urandom % 36), 8'($urandom % 36),
                         8'($urandom % 36)});
            rd = $urandom % NREGS;
            vl = $urandom % 6;
            fn = {2'($urandom), (($urandom % 8) == 0) ? 2'($urandom) : 2'b10};
            run(OP, 3'b000, fn, rd, rs1, vl, "R8");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule